// File: doc/BRIEF.md
# Serial-Programmed Synthesizer Control Latches

This block is the digital programming front end of a frequency synthesizer. A host writes 24-bit control words over a write-only three-wire link made of a serial clock, a data line and a latch strobe. The two least significant bits of each word choose which of four holding registers receives it: the reference-divider register, the swallow/main-counter register, the function register or the initialization register. The initialization register loads the same fields as the function register and also resynchronises the divider chain.

Beyond storing fields, the block produces the control events the divider and charge-pump logic need. It issues one-cycle counter-reset pulses on an initialization write and on the first swallow/main-counter write after one. It decides whether the synthesizer is powered down, either at once or on the next charge-pump event. It tristates the charge pump when asked to. It runs the fast-lock timer, which returns the charge-pump current selection to the primary setting by clearing the gain bit on its own. All serial inputs pass through synchronisers into the system clock domain. The charge-pump event and reference-cycle strobes arrive as single-cycle pulses that are already synchronous to that clock.

Top module: `synth_ctl_latches`

## Requirements
- R1: Data shifts in most significant bit first on each rising edge of `ser_clk`. On each rising edge of `ser_le`, the shift register is copied to the register chosen by word bits [1:0]: 00 reference (r_div = [15:2], pulse_width = [17:16], lock_prec = [20]), 01 counter (a_val = [7:2], b_val = [20:8], gain = [21]), 10 function, 11 initialization (both function fields: cnt_hold [2], pd1 [3], mux_sel [6:4], pd_polarity [7], cp_tri [8], fl_en [9], fl_mode [10], timeout code [14:11], cur_set1 [17:15], cur_set2 [20:18], pd2 [21], presc_sel [23:22]).
- R2: A strobe that follows fewer than 24 clock edges still transfers the shift register as it stands. The register is never cleared, so older bits move up by the number of new bits.
- R3: An initialization write drives `cnt_rst` high for exactly one clock cycle and loads the function fields.
- R4: The first counter-register write after an initialization write gives one more one-cycle `cnt_rst` pulse. Later counter writes, and counter writes with no initialization before them, give none.
- R5: While cnt_hold is 1, `cnt_rst` and `cp_tristate` stay high. Whenever `pwr_down` is high, `cnt_rst` and `cp_tristate` are also high.
- R6: With `chip_en` low, `pwr_down` is high in the same cycle, whatever the power-down bits hold.
- R7: A function write with pd1 = 1 and pd2 = 0 powers the block down without waiting for a charge-pump event. A function write with pd1 = 0 powers it back up.
- R8: A function write with pd1 = 1 and pd2 = 1 leaves `pwr_down` low until the next `cp_event` pulse, and sets it in the cycle after that pulse.
- R9: With fl_en = 0, `cur_sel` stays 0 even when the gain bit is set.
- R10: With fl_en = 1 and fl_mode = 0, `cur_sel` follows the gain bit and ignores `ref_tick`. Only a counter write with gain = 0 returns it to 0.
- R11: With fl_en = 1 and fl_mode = 1, a counter write with gain = 1 sets `cur_sel`. After exactly (code + 1) × 4 `ref_tick` pulses the gain bit clears by itself and `cur_sel` returns to 0.
- R12: Function bit cp_tri = 1 drives `cp_tristate` high without asserting `cnt_rst`.
- R13: Serial writes are still accepted and stored while the block is powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch strobe; its rising edge transfers the word |
| chip_en | input | 1 | Chip enable; low forces power-down |
| cp_event | input | 1 | Single-cycle charge-pump event strobe |
| ref_tick | input | 1 | Single-cycle reference-cycle strobe for the fast-lock timer |
| r_div | output | 14 | Reference divide ratio |
| pulse_width | output | 2 | Anti-dead-zone pulse width code |
| lock_prec | output | 1 | Lock-detect precision select |
| a_val | output | 6 | Swallow counter value |
| b_val | output | 13 | Main counter value |
| presc_sel | output | 2 | Prescaler modulus select |
| mux_sel | output | 3 | Test/lock multiplexer select |
| pd_polarity | output | 1 | Phase detector polarity |
| cur_set1 | output | 3 | Primary charge-pump current code |
| cur_set2 | output | 3 | Secondary charge-pump current code |
| cur_sel | output | 1 | 1 selects the secondary current |
| cnt_rst | output | 1 | Divider counter reset (pulse or hold) |
| pwr_down | output | 1 | Power-down state |
| cp_tristate | output | 1 | Charge-pump tristate control |

## Verification
The bench counts `cnt_rst` high cycles around each write. A design that rearms the reset pulse on every counter write, or never arms it, shows an extra or a missing pulse. A truncated transfer checks that the shift register keeps its old bits. A design that clears the register after each strobe would load a different main-counter value. The synchronous power-down case holds back `cp_event` to catch a design that powers down at once. The fast-lock timeout is checked one tick before and exactly at the limit for the shortest, a middle and the longest codes, which exposes an off-by-one count or a wrong lookup.

// File: rtl/synctl_pkg.sv
package synctl_pkg;

   localparam int WORD_W  = 24;
   localparam int SEL_W   = 2;
   localparam int RDIV_W  = 14;
   localparam int A_W     = 6;
   localparam int B_W     = 13;
   localparam int TCODE_W = 4;
   localparam int NCODES  = 1 << TCODE_W;

   typedef enum logic [SEL_W-1:0] {
      SEL_REF  = 2'b00,
      SEL_AB   = 2'b01,
      SEL_FUNC = 2'b10,
      SEL_INIT = 2'b11
   } latch_sel_e;

   // function / initialization payload, word[23:2]
   typedef struct packed {
      logic [1:0]         presc;
      logic               pd2;
      logic [2:0]         cur2;
      logic [2:0]         cur1;
      logic [TCODE_W-1:0] tcode;
      logic               fl_mode;
      logic               fl_en;
      logic               cp_tri;
      logic               polarity;
      logic [2:0]         mux;
      logic               pd1;
      logic               cnt_hold;
   } func_t;

   typedef struct packed {
      logic              lock_prec;
      logic [1:0]        pwidth;
      logic [RDIV_W-1:0] rdiv;
   } ref_t;

   // counter payload, word[21:2]
   typedef struct packed {
      logic           gain;
      logic [B_W-1:0] b;
      logic [A_W-1:0] a;
   } ab_t;

endpackage

// File: rtl/synctl_sync.sv
module synctl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] pipe;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("synctl_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-2:0], din};
   end

   assign dout = pipe[STAGES-1];
endmodule

// File: rtl/synctl_shift.sv
module synctl_shift
   import synctl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_lvl,
   input  logic              data_lvl,
   input  logic              le_lvl,
   output logic [WORD_W-1:0] word,
   output logic              word_vld
);
   logic clk_prev, le_prev;
   logic [WORD_W-1:0] sreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_prev <= 1'b0;
         le_prev  <= 1'b0;
         sreg     <= '0;
      end else begin
         clk_prev <= clk_lvl;
         le_prev  <= le_lvl;
         if (clk_lvl && !clk_prev) sreg <= {sreg[WORD_W-2:0], data_lvl};
      end
   end

   // no bit count: a short burst transfers whatever is held
   assign word     = sreg;
   assign word_vld = le_lvl && !le_prev;
endmodule

// File: rtl/synctl_regs.sv
module synctl_regs
   import synctl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word,
   input  logic              word_vld,
   input  logic              gain_clr,
   output func_t             func_q,
   output ref_t              ref_q,
   output ab_t               ab_q,
   output logic              rst_pulse,
   output logic              ab_wr,
   output logic              func_wr,
   output logic              init_wr
);
   logic armed;
   latch_sel_e sel;

   assign sel = latch_sel_e'(word[SEL_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         func_q    <= '0;
         ref_q     <= '0;
         ab_q      <= '0;
         rst_pulse <= 1'b0;
         ab_wr     <= 1'b0;
         func_wr   <= 1'b0;
         init_wr   <= 1'b0;
         armed     <= 1'b0;
      end else begin
         rst_pulse <= 1'b0;
         ab_wr     <= 1'b0;
         func_wr   <= 1'b0;
         init_wr   <= 1'b0;
         if (gain_clr) ab_q.gain <= 1'b0;
         if (word_vld) begin
            case (sel)
               SEL_REF: begin
                  ref_q.rdiv      <= word[RDIV_W+1:2];
                  ref_q.pwidth    <= word[17:16];
                  ref_q.lock_prec <= word[20];
               end
               SEL_AB: begin
                  ab_q  <= ab_t'(word[A_W+B_W+2:2]);
                  ab_wr <= 1'b1;
                  if (armed) begin
                     rst_pulse <= 1'b1;
                     armed     <= 1'b0;
                  end
               end
               SEL_FUNC: begin
                  func_q  <= func_t'(word[WORD_W-1:2]);
                  func_wr <= 1'b1;
               end
               SEL_INIT: begin
                  func_q    <= func_t'(word[WORD_W-1:2]);
                  init_wr   <= 1'b1;
                  rst_pulse <= 1'b1;
                  armed     <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/synctl_power.sv
module synctl_power (
   input  logic clk,
   input  logic rst_n,
   input  logic func_wr,
   input  logic init_wr,
   input  logic pd1,
   input  logic pd2,
   input  logic cp_event,
   output logic pd_prog
);
   logic pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd_prog <= 1'b0;
         pending <= 1'b0;
      end else if (func_wr || init_wr) begin
         if (!pd1) begin
            pd_prog <= 1'b0;
            pending <= 1'b0;
         end else if (!pd2 || init_wr) begin
            // asynchronous mode, or the init pulse acts as the trigger
            pd_prog <= 1'b1;
            pending <= 1'b0;
         end else begin
            pending <= 1'b1;
         end
      end else if (pending && cp_event) begin
         pd_prog <= 1'b1;
         pending <= 1'b0;
      end
   end
endmodule

// File: rtl/synctl_fastlock.sv
module synctl_fastlock
   import synctl_pkg::*;
#(
   parameter int TICK_STEP = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fl_en,
   input  logic               fl_mode,
   input  logic [TCODE_W-1:0] tcode,
   input  logic               gain,
   input  logic               ab_wr,
   input  logic               timer_rst,
   input  logic               ref_tick,
   output logic               gain_clr,
   output logic               cur_sel
);
   localparam int MAX_TICKS = NCODES * TICK_STEP;
   localparam int CNT_W     = $clog2(MAX_TICKS + 1);

   logic [CNT_W-1:0] limit_lut [NCODES];
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last_cnt;
   logic             run;

   generate
      if (TICK_STEP < 1) begin : g_bad_step
         $error("synctl_fastlock: TICK_STEP must be positive");
      end
      for (genvar g = 0; g < NCODES; g++) begin : g_lut
         assign limit_lut[g] = CNT_W'((g + 1) * TICK_STEP);
      end
   endgenerate

   assign run      = fl_en && fl_mode && gain;
   assign last_cnt = limit_lut[tcode] - CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt <= '0;
      else if (ab_wr || timer_rst || !run) cnt <= '0;
      else if (ref_tick)                   cnt <= cnt + CNT_W'(1);
   end

   assign gain_clr = run && ref_tick && !ab_wr && !timer_rst && (cnt == last_cnt);
   assign cur_sel  = fl_en && gain;
endmodule

// File: rtl/synth_ctl_latches.sv
module synth_ctl_latches
   import synctl_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int TICK_STEP   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_data,
   input  logic              ser_le,
   input  logic              chip_en,
   input  logic              cp_event,
   input  logic              ref_tick,
   output logic [RDIV_W-1:0] r_div,
   output logic [1:0]        pulse_width,
   output logic              lock_prec,
   output logic [A_W-1:0]    a_val,
   output logic [B_W-1:0]    b_val,
   output logic [1:0]        presc_sel,
   output logic [2:0]        mux_sel,
   output logic              pd_polarity,
   output logic [2:0]        cur_set1,
   output logic [2:0]        cur_set2,
   output logic              cur_sel,
   output logic              cnt_rst,
   output logic              pwr_down,
   output logic              cp_tristate
);
   logic              clk_lvl, data_lvl, le_lvl;
   logic [WORD_W-1:0] word;
   logic              word_vld;
   func_t             func_q;
   ref_t              ref_q;
   ab_t               ab_q;
   logic              rst_pulse, ab_wr, func_wr, init_wr, gain_clr, pd_prog;

   synctl_sync #(.STAGES(SYNC_STAGES)) i_sync_clk (
      .clk(clk), .rst_n(rst_n), .din(ser_clk), .dout(clk_lvl));
   synctl_sync #(.STAGES(SYNC_STAGES)) i_sync_data (
      .clk(clk), .rst_n(rst_n), .din(ser_data), .dout(data_lvl));
   synctl_sync #(.STAGES(SYNC_STAGES)) i_sync_le (
      .clk(clk), .rst_n(rst_n), .din(ser_le), .dout(le_lvl));

   synctl_shift i_shift (
      .clk(clk), .rst_n(rst_n), .clk_lvl(clk_lvl), .data_lvl(data_lvl),
      .le_lvl(le_lvl), .word(word), .word_vld(word_vld));

   synctl_regs i_regs (
      .clk(clk), .rst_n(rst_n), .word(word), .word_vld(word_vld),
      .gain_clr(gain_clr), .func_q(func_q), .ref_q(ref_q), .ab_q(ab_q),
      .rst_pulse(rst_pulse), .ab_wr(ab_wr), .func_wr(func_wr), .init_wr(init_wr));

   synctl_power i_power (
      .clk(clk), .rst_n(rst_n), .func_wr(func_wr), .init_wr(init_wr),
      .pd1(func_q.pd1), .pd2(func_q.pd2), .cp_event(cp_event), .pd_prog(pd_prog));

   synctl_fastlock #(.TICK_STEP(TICK_STEP)) i_fastlock (
      .clk(clk), .rst_n(rst_n), .fl_en(func_q.fl_en), .fl_mode(func_q.fl_mode),
      .tcode(func_q.tcode), .gain(ab_q.gain), .ab_wr(ab_wr), .timer_rst(cnt_rst),
      .ref_tick(ref_tick), .gain_clr(gain_clr), .cur_sel(cur_sel));

   assign pwr_down    = !chip_en || pd_prog;
   assign cnt_rst     = rst_pulse || func_q.cnt_hold || pwr_down;
   assign cp_tristate = cnt_rst || func_q.cp_tri;

   assign r_div       = ref_q.rdiv;
   assign pulse_width = ref_q.pwidth;
   assign lock_prec   = ref_q.lock_prec;
   assign a_val       = ab_q.a;
   assign b_val       = ab_q.b;
   assign presc_sel   = func_q.presc;
   assign mux_sel     = func_q.mux;
   assign pd_polarity = func_q.polarity;
   assign cur_set1    = func_q.cur1;
   assign cur_set2    = func_q.cur2;
endmodule

// File: rtl/synctl_chk.sv
module synctl_chk (
   input logic clk,
   input logic rst_n,
   input logic chip_en,
   input logic pwr_down,
   input logic cnt_rst,
   input logic cp_tristate,
   input logic cur_sel,
   input logic rst_pulse,
   input logic fl_en,
   input logic cp_tri
);
   // R6
   chip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_en |-> pwr_down);

   // R5
   down_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |-> (cnt_rst && cp_tristate));

   // R3
   pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |=> !rst_pulse);

   // R9
   fl_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cur_sel |-> fl_en);

   // R12
   tri_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cp_tri |-> cp_tristate);
endmodule

bind synth_ctl_latches synctl_chk i_synctl_chk (
   .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .pwr_down(pwr_down),
   .cnt_rst(cnt_rst), .cp_tristate(cp_tristate), .cur_sel(cur_sel),
   .rst_pulse(rst_pulse), .fl_en(func_q.fl_en), .cp_tri(func_q.cp_tri));

// File: tb/test_synth_ctl_latches.sv
module test_synth_ctl_latches;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
   logic chip_en = 1'b1, cp_event = 1'b0, ref_tick = 1'b0;
   logic [13:0] r_div;
   logic [1:0]  pulse_width, presc_sel;
   logic        lock_prec, pd_polarity, cur_sel, cnt_rst, pwr_down, cp_tristate;
   logic [5:0]  a_val;
   logic [12:0] b_val;
   logic [2:0]  mux_sel, cur_set1, cur_set2;

   int n_chk = 0, n_bad = 0, hi_cnt = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   synth_ctl_latches i_synth_ctl_latches (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
      .chip_en(chip_en), .cp_event(cp_event), .ref_tick(ref_tick),
      .r_div(r_div), .pulse_width(pulse_width), .lock_prec(lock_prec),
      .a_val(a_val), .b_val(b_val), .presc_sel(presc_sel), .mux_sel(mux_sel),
      .pd_polarity(pd_polarity), .cur_set1(cur_set1), .cur_set2(cur_set2),
      .cur_sel(cur_sel), .cnt_rst(cnt_rst), .pwr_down(pwr_down), .cp_tristate(cp_tristate));

   always @(negedge clk) if (rst_n && cnt_rst) hi_cnt++;

   // entry: addr[43:42] payload[41:20] sel[19:16] exp[15:0]; word = {payload, addr}
   localparam logic [43:0] VEC [10] = '{
      {2'b00, {3'b0, 1'b0, 2'b0, 2'd2, 14'h2A5B}, 4'd0, 16'h2A5B},
      {2'b00, {3'b0, 1'b1, 2'b0, 2'd3, 14'h3FFF}, 4'd7, 16'd3},
      {2'b00, {3'b0, 1'b1, 2'b0, 2'd0, 14'h0001}, 4'd8, 16'd1},
      {2'b01, {2'b0, 1'b0, 13'h1ABC, 6'h2D}, 4'd1, 16'h002D},
      {2'b01, {2'b0, 1'b0, 13'h1FFF, 6'h3F}, 4'd2, 16'h1FFF},
      {2'b10, {2'd2, 1'b0, 3'd6, 3'd3, 4'd0, 4'b0000, 3'd5, 2'b00}, 4'd3, 16'd2},
      {2'b10, {2'd1, 1'b0, 3'd6, 3'd3, 4'd0, 4'b0000, 3'd5, 2'b00}, 4'd6, 16'd5},
      {2'b11, {2'd0, 1'b0, 3'd1, 3'd7, 4'd0, 4'b0000, 3'd2, 2'b00}, 4'd4, 16'd7},
      {2'b10, {2'd0, 1'b0, 3'd1, 3'd0, 4'd0, 4'b0000, 3'd0, 2'b00}, 4'd5, 16'd1},
      {2'b10, {2'd0, 1'b0, 3'd0, 3'd0, 4'd0, 4'b0001, 3'd0, 2'b00}, 4'd9, 16'd1}
   };

   function automatic logic [15:0] pick(input logic [3:0] sel);
      case (sel)
         4'd0: pick = 16'(r_div);
         4'd1: pick = 16'(a_val);
         4'd2: pick = 16'(b_val);
         4'd3: pick = 16'(presc_sel);
         4'd4: pick = 16'(cur_set1);
         4'd5: pick = 16'(cur_set2);
         4'd6: pick = 16'(mux_sel);
         4'd7: pick = 16'(pulse_width);
         4'd8: pick = 16'(lock_prec);
         default: pick = 16'(pd_polarity);
      endcase
   endfunction

   function automatic logic [23:0] fword(input logic hold, pd1, cptri, flen, flmode,
                                         input logic [3:0] tc, input logic pd2);
      fword = {2'd0, pd2, 3'd0, 3'd0, tc, flmode, flen, cptri, 1'b0, 3'd0, pd1, hold, 2'b10};
   endfunction

   function automatic logic [23:0] abword(input logic gain, input logic [12:0] b,
                                          input logic [5:0] a);
      abword = {2'b0, gain, b, a, 2'b01};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_bits(input logic [23:0] w, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         @(negedge clk); ser_data = w[i];
         repeat (2) @(negedge clk); ser_clk = 1'b1;
         repeat (3) @(negedge clk); ser_clk = 1'b0;
      end
      repeat (2) @(negedge clk); ser_le = 1'b1;
      repeat (3) @(negedge clk); ser_le = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic send(input logic [23:0] w);
      send_bits(w, 24);
   endtask

   task automatic send_count(input logic [23:0] w);
      @(posedge clk); hi_cnt = 0;
      send(w);
   endtask

   task automatic tick();
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
   endtask

   task automatic timeout_case(input logic [3:0] code);
      int lim;
      lim = (int'(code) + 1) * 4;
      send(fword(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, code, 1'b0));
      send(abword(1'b1, 13'd9, 6'd3));
      chk("R11 cur_sel set by gain", cur_sel, 1);
      for (int k = 0; k < lim - 1; k++) tick();
      repeat (2) @(negedge clk);
      chk("R11 one tick before timeout", cur_sel, 1);
      tick();
      repeat (2) @(negedge clk);
      chk("R11 cleared at timeout", cur_sel, 0);
   endtask

   initial begin
      logic [23:0] w;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1: table of writes and field read-backs
      for (int v = 0; v < 10; v++) begin
         send({VEC[v][41:20], VEC[v][43:42]});
         chk($sformatf("R1 vector %0d", v), pick(VEC[v][19:16]), VEC[v][15:0]);
      end

      // reset state
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk); rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("reset r_div", r_div, 0);
      chk("reset cnt_rst", cnt_rst, 0);
      chk("reset pwr_down", pwr_down, 0);
      chk("reset cur_sel", cur_sel, 0);
      chk("reset cp_tristate", cp_tristate, 0);

      // R4: counter write with no initialization before it
      send_count(abword(1'b0, 13'd100, 6'd5));
      chk("R4 no pulse without init", hi_cnt, 0);
      // R3: initialization write
      send_count({2'd3, 1'b0, 3'd2, 3'd4, 4'd0, 4'b0000, 3'd1, 2'b00, 2'b11});
      chk("R3 init pulse width", hi_cnt, 1);
      chk("R3 init loads presc", presc_sel, 3);
      send_count(abword(1'b0, 13'd200, 6'd6));
      chk("R4 first counter write after init", hi_cnt, 1);
      send_count(abword(1'b0, 13'd201, 6'd7));
      chk("R4 second counter write", hi_cnt, 0);

      // R5 counter hold
      send(fword(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0));
      chk("R5 hold cnt_rst", cnt_rst, 1);
      chk("R5 hold cp_tristate", cp_tristate, 1);
      send(fword(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0));
      chk("R5 hold released", cnt_rst, 0);

      // R12 tristate bit
      send(fword(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0));
      chk("R12 cp_tristate", cp_tristate, 1);
      chk("R12 no counter reset", cnt_rst, 0);
      send(fword(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0));
      chk("R12 cp_tristate off", cp_tristate, 0);

      // R2 short transfer
      w = {3'b0, 1'b0, 2'b0, 2'd0, 14'h1234, 2'b00};
      send(w);
      send_bits(24'h000001, 8);
      chk("R2 short word b_val", b_val, 32'(w[12:0]));
      chk("R2 short word a_val", a_val, 0);

      // R6 chip enable, R13 writes while down
      @(negedge clk); chip_en = 1'b0; #1;
      chk("R6 pwr_down immediate", pwr_down, 1);
      chk("R6 cnt_rst while down", cnt_rst, 1);
      send({3'b0, 1'b0, 2'b0, 2'd1, 14'h0777, 2'b00});
      chk("R13 write while down", r_div, 14'h0777);
      @(negedge clk); chip_en = 1'b1; #1;
      chk("R6 power restored", pwr_down, 0);

      // R7 asynchronous programmed power-down
      send(fword(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0));
      chk("R7 async power-down", pwr_down, 1);
      send(fword(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0));
      chk("R7 power-up", pwr_down, 0);

      // R8 synchronous programmed power-down
      send(fword(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1));
      repeat (10) @(negedge clk);
      chk("R8 waits for cp event", pwr_down, 0);
      @(negedge clk); cp_event = 1'b1;
      @(negedge clk); cp_event = 1'b0;
      chk("R8 down after cp event", pwr_down, 1);
      send(fword(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0));
      chk("R8 power-up", pwr_down, 0);

      // R9 fast lock disabled
      send(abword(1'b1, 13'd50, 6'd1));
      chk("R9 disabled cur_sel", cur_sel, 0);

      // R10 mode 1
      send(fword(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0));
      send(abword(1'b1, 13'd51, 6'd1));
      chk("R10 mode1 set", cur_sel, 1);
      for (int k = 0; k < 100; k++) tick();
      repeat (2) @(negedge clk);
      chk("R10 mode1 ignores ticks", cur_sel, 1);
      send(abword(1'b0, 13'd52, 6'd1));
      chk("R10 mode1 cleared by write", cur_sel, 0);

      // R11 mode 2 timeouts
      timeout_case(4'd0);
      timeout_case(4'd2);
      timeout_case(4'd15);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule